// File: doc/BRIEF.md
# Small-Page NAND Command and Address Sequencer

This block runs the command and address phases of one operation on a small-page NAND flash device that has an 8-bit bus. A request carries a command code, a column that may be present or absent, and a page number that may be present or absent. The block puts the command byte or bytes on the bus with the command latch enable high. It then puts the address bytes on the bus with the address latch enable high. Each byte is clocked into the device by a low pulse on an active-low write strobe. The block then releases the bus and waits a fixed settling time before it pulses done.

For the sequential data input command, the block first sends the pointer command that selects the page region holding the column. The choice depends on the page size and the column, and the column is rebased to that region. Moving the data, computing ECC and watching ready/busy are handled elsewhere. A request is accepted only while the block is idle.

Top module: `nic_issuer`

## Requirements
- R1: In reset, and whenever the block is idle, busy_o, done_o, cle_o, ale_o and bus_oe_o are 0 and we_no is 1.
- R2: A command code other than 0x80 is sent as exactly one byte with cle_o=1 and ale_o=0.
- R3: With PAGE_BYTES=256, command 0x80 with a column of 256 or more sends the command bytes 0xFF, 0x50, 0x80 in that order. The column byte sent is (column-256)[7:0].
- R4: With PAGE_BYTES=512, command 0x80 with a column from 256 to 511 sends 0x01 and then 0x80. The column byte sent is (column-256)[7:0].
- R5: With PAGE_BYTES=512, command 0x80 with a column of 512 or more sends 0x50 and then 0x80. The column byte sent is (column-512)[7:0].
- R6: In every other case of command 0x80 (column below 256, or no column), the block sends 0x00 and then 0x80, and the column is left unchanged.
- R7: A column byte is sent only when req_has_col_i=1. It is a single byte, and it is the first byte sent with ale_o=1.
- R8: When req_has_page_i=1, the page number is sent with ale_o=1 after the column, least significant byte first. Bits 23:16 are sent as a third byte only when DEV_SIZE & 0x0C000000 is non-zero; otherwise two bytes are sent.
- R9: Every byte is strobed by we_no held low for exactly WE_CLKS clocks, with bus_oe_o=1 and bus_o stable while it is low.
- R10: After the last byte, cle_o, ale_o and bus_oe_o are 0 for CLK_MHZ*SETTLE_US clocks. done_o is then high for one clock, and the block returns to idle.
- R11: req_valid_i is ignored while busy_o=1. busy_o stays high until done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken when idle |
| req_cmd_i | input | 8 | Command code |
| req_has_col_i | input | 1 | Column present |
| req_col_i | input | COL_W | Column within the page and spare area |
| req_has_page_i | input | 1 | Page number present |
| req_page_i | input | 24 | Page number |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-clock pulse when the settling time has elapsed |
| cle_o | output | 1 | Command latch enable |
| ale_o | output | 1 | Address latch enable |
| we_no | output | 1 | Write strobe, active low |
| bus_oe_o | output | 1 | Block drives the data bus |
| bus_o | output | 8 | Byte on the data bus |

## Verification
Two instances are driven from the same requests: one with 512-byte pages and a three-byte page number, and one with 256-byte pages and a two-byte page number. Sequential input commands are sent with columns of 0x10, 255, 300, 511 and 520, and once with no column. These separate the region decode on each side of 256 and 512, and the two page sizes at the same column. Plain commands are sent with a full address, with a column only and with no address, which shows whether the column and page bytes are included or left out. A second request sent while busy checks that it is dropped. Every byte has its strobe width measured, and every request has its settling time measured.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam logic [7:0] OP_READ0   = 8'h00;
  localparam logic [7:0] OP_READ1   = 8'h01;
  localparam logic [7:0] OP_READOOB = 8'h50;
  localparam logic [7:0] OP_SEQIN   = 8'h80;
  localparam logic [7:0] OP_RESET   = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_SETTLE, ST_DONE
  } st_e;

  typedef struct packed {
    logic [2:0][7:0] cmd;
    logic [1:0]      n_cmd;
    logic [3:0][7:0] addr;
    logic [2:0]      n_addr;
  } plan_t;
endpackage

// File: rtl/nic_plan.sv
module nic_plan import nic_pkg::*; #(
  parameter int          PAGE_BYTES = 512,
  parameter logic [31:0] DEV_SIZE   = 32'h0400_0000,
  parameter int          COL_W      = 10
) (
  input  logic [7:0]       cmd_i,
  input  logic             has_col_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             has_page_i,
  input  logic [23:0]      page_i,
  output plan_t            plan_o
);
  localparam int PG_N = ((DEV_SIZE & 32'h0C00_0000) != 32'd0) ? 3 : 2;

  logic [31:0] col_w;
  logic        ptr_two;
  logic [7:0]  ptr0, ptr1, col_out;

  assign col_w = 32'(col_i);

  generate
    if (PAGE_BYTES == 256) begin : g_small
      always_comb begin
        if (has_col_i && col_w >= 32'd256) begin
          ptr_two = 1'b1;
          ptr0    = OP_RESET;
          ptr1    = OP_READOOB;
          col_out = 8'(col_w - 32'd256);
        end else begin
          ptr_two = 1'b0;
          ptr0    = OP_READ0;
          ptr1    = OP_SEQIN;
          col_out = col_w[7:0];
        end
      end
    end else begin : g_large
      always_comb begin
        ptr_two = 1'b0;
        ptr1    = OP_SEQIN;
        if (has_col_i && col_w >= 32'd512) begin
          ptr0    = OP_READOOB;
          col_out = 8'(col_w - 32'd512);
        end else if (has_col_i && col_w >= 32'd256) begin
          ptr0    = OP_READ1;
          col_out = 8'(col_w - 32'd256);
        end else begin
          ptr0    = OP_READ0;
          col_out = col_w[7:0];
        end
      end
    end
  endgenerate

  logic        is_seq;
  logic [7:0]  col_byte;
  logic [31:0] pg;

  assign is_seq   = (cmd_i == OP_SEQIN);
  assign col_byte = is_seq ? col_out : col_w[7:0];
  assign pg       = {8'h00, page_i};

  always_comb begin
    plan_o = '0;
    if (is_seq) begin
      plan_o.cmd[0] = ptr0;
      plan_o.cmd[1] = ptr1;
      plan_o.cmd[2] = OP_SEQIN;
      plan_o.n_cmd  = ptr_two ? 2'd3 : 2'd2;
    end else begin
      plan_o.cmd[0] = cmd_i;
      plan_o.n_cmd  = 2'd1;
    end
    if (has_col_i) plan_o.addr = {pg[23:0], col_byte};
    else           plan_o.addr = pg;
    plan_o.n_addr = {2'b00, has_col_i} + (has_page_i ? 3'(PG_N) : 3'd0);
  end
endmodule

// File: rtl/nic_we_strobe.sv
module nic_we_strobe #(
  parameter int PULSE = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  output logic we_no,
  output logic fin_o
);
  localparam int CW = (PULSE > 1) ? $clog2(PULSE) : 1;
  localparam logic [CW-1:0] LAST = CW'(PULSE - 1);

  logic          act_q, low_q;
  logic [CW-1:0] cnt_q;

  assign we_no = ~low_q;
  assign fin_o = act_q & ~low_q & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      low_q <= 1'b0;
      cnt_q <= '0;
    end else if (!act_q) begin
      if (go_i) begin
        act_q <= 1'b1;
        low_q <= 1'b1;
        cnt_q <= '0;
      end
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      if (low_q) low_q <= 1'b0;
      else       act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/nic_settle.sv
module nic_settle #(
  parameter int CYCLES = 3750
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic fin_o
);
  localparam int SW = $clog2(CYCLES + 1);
  localparam logic [SW-1:0] LAST = SW'(CYCLES - 1);

  logic [SW-1:0] cnt_q;

  assign fin_o = en_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (!fin_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/nic_issuer.sv
module nic_issuer import nic_pkg::*; #(
  parameter int          PAGE_BYTES = 512,
  parameter logic [31:0] DEV_SIZE   = 32'h0400_0000,
  parameter int          COL_W      = 10,
  parameter int          WE_CLKS    = 2,
  parameter int          CLK_MHZ    = 250,
  parameter int          SETTLE_US  = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [7:0]       req_cmd_i,
  input  logic             req_has_col_i,
  input  logic [COL_W-1:0] req_col_i,
  input  logic             req_has_page_i,
  input  logic [23:0]      req_page_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             cle_o,
  output logic             ale_o,
  output logic             we_no,
  output logic             bus_oe_o,
  output logic [7:0]       bus_o
);
  localparam int SETTLE_CLKS = CLK_MHZ * SETTLE_US;

  st_e        st_q;
  plan_t      plan_d, plan_q;
  logic [2:0] idx_q;
  logic       go, byte_fin, settle_fin, last_cmd, last_addr;
  logic [7:0] cmd_byte, addr_byte;

  nic_plan #(.PAGE_BYTES(PAGE_BYTES), .DEV_SIZE(DEV_SIZE), .COL_W(COL_W)) u_plan (
    .cmd_i(req_cmd_i), .has_col_i(req_has_col_i), .col_i(req_col_i),
    .has_page_i(req_has_page_i), .page_i(req_page_i), .plan_o(plan_d)
  );

  assign go = (st_q == ST_CMD) || (st_q == ST_ADDR);

  nic_we_strobe #(.PULSE(WE_CLKS)) u_strobe (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(go), .we_no(we_no), .fin_o(byte_fin)
  );

  nic_settle #(.CYCLES(SETTLE_CLKS)) u_settle (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(st_q == ST_SETTLE), .fin_o(settle_fin)
  );

  assign last_cmd  = (idx_q + 3'd1) == {1'b0, plan_q.n_cmd};
  assign last_addr = (idx_q + 3'd1) == plan_q.n_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      plan_q <= '0;
      idx_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          plan_q <= plan_d;
          idx_q  <= '0;
          st_q   <= ST_CMD;
        end
        ST_CMD: if (byte_fin) begin
          if (last_cmd) begin
            idx_q <= '0;
            st_q  <= (plan_q.n_addr == 3'd0) ? ST_SETTLE : ST_ADDR;
          end else begin
            idx_q <= idx_q + 3'd1;
          end
        end
        ST_ADDR: if (byte_fin) begin
          if (last_addr) begin
            idx_q <= '0;
            st_q  <= ST_SETTLE;
          end else begin
            idx_q <= idx_q + 3'd1;
          end
        end
        ST_SETTLE: if (settle_fin) st_q <= ST_DONE;
        ST_DONE:   st_q <= ST_IDLE;
        default:   st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (idx_q)
      3'd1:    cmd_byte = plan_q.cmd[1];
      3'd2:    cmd_byte = plan_q.cmd[2];
      default: cmd_byte = plan_q.cmd[0];
    endcase
    case (idx_q)
      3'd1:    addr_byte = plan_q.addr[1];
      3'd2:    addr_byte = plan_q.addr[2];
      3'd3:    addr_byte = plan_q.addr[3];
      default: addr_byte = plan_q.addr[0];
    endcase
  end

  assign busy_o   = (st_q != ST_IDLE);
  assign done_o   = (st_q == ST_DONE);
  assign cle_o    = (st_q == ST_CMD);
  assign ale_o    = (st_q == ST_ADDR);
  assign bus_oe_o = go;
  assign bus_o    = (st_q == ST_CMD) ? cmd_byte : (st_q == ST_ADDR) ? addr_byte : 8'h00;
endmodule

// File: rtl/nic_checks.sv
module nic_checks (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_o,
  input logic       done_o,
  input logic       cle_o,
  input logic       ale_o,
  input logic       we_no,
  input logic       bus_oe_o,
  input logic [7:0] bus_o
);
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (we_no && !cle_o && !ale_o && !bus_oe_o && !done_o));

  a_r2_latch_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cle_o && ale_o));

  a_r9_strobe_driven: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> (bus_oe_o && (cle_o || ale_o)));

  a_r9_bus_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_no && !$past(we_no)) |-> $stable(bus_o));

  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);

  a_r10_done_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!bus_oe_o && !cle_o && !ale_o && we_no));

  a_r11_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
endmodule

bind nic_issuer nic_checks u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .cle_o(cle_o), .ale_o(ale_o), .we_no(we_no), .bus_oe_o(bus_oe_o), .bus_o(bus_o)
);

// File: tb/sim_nic_issuer.sv
module nic_mon #(parameter int WE_CLKS = 3) (
  input logic       clk,
  input logic       rst_n,
  input logic       clr,
  input logic       we_n,
  input logic       cle,
  input logic       ale,
  input logic       oe,
  input logic       busy,
  input logic       done,
  input logic [7:0] bus
);
  logic [7:0] byte_q [16];
  logic [1:0] kind_q [16];
  int n, low_run, bad_we, settle, dones;
  logic prev_we;

  always @(negedge clk) begin
    if (clr || !rst_n) begin
      n = 0; low_run = 0; bad_we = 0; settle = 0; dones = 0; prev_we = 1'b1;
    end else begin
      if (!we_n) low_run++;
      if (!prev_we && we_n) begin
        if (low_run != WE_CLKS) bad_we++;
        low_run = 0;
        if (n < 16) begin
          byte_q[n] = bus;
          kind_q[n] = {cle, ale};
          n++;
        end
      end
      prev_we = we_n;
      if (busy && !oe && !done && !cle && !ale) settle++;
      if (done) dones++;
    end
  end
endmodule

module sim_nic_issuer;
  localparam int WE = 3;
  localparam int SETTLE = 250 * 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic req_valid = 1'b0;
  logic [7:0] req_cmd = 8'h00;
  logic req_hc = 1'b0;
  logic [9:0] req_col = '0;
  logic req_hp = 1'b0;
  logic [23:0] req_page = '0;
  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  logic busy0, done0, cle0, ale0, we0, oe0, busy1, done1, cle1, ale1, we1, oe1;
  logic [7:0] bus0, bus1;

  nic_issuer #(.PAGE_BYTES(512), .DEV_SIZE(32'h0400_0000), .WE_CLKS(WE)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_cmd_i(req_cmd),
    .req_has_col_i(req_hc), .req_col_i(req_col), .req_has_page_i(req_hp),
    .req_page_i(req_page), .busy_o(busy0), .done_o(done0), .cle_o(cle0),
    .ale_o(ale0), .we_no(we0), .bus_oe_o(oe0), .bus_o(bus0));

  nic_issuer #(.PAGE_BYTES(256), .DEV_SIZE(32'h0020_0000), .WE_CLKS(WE)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_cmd_i(req_cmd),
    .req_has_col_i(req_hc), .req_col_i(req_col), .req_has_page_i(req_hp),
    .req_page_i(req_page), .busy_o(busy1), .done_o(done1), .cle_o(cle1),
    .ale_o(ale1), .we_no(we1), .bus_oe_o(oe1), .bus_o(bus1));

  nic_mon #(.WE_CLKS(WE)) m0 (.clk(clk), .rst_n(rst_n), .clr(clr), .we_n(we0),
    .cle(cle0), .ale(ale0), .oe(oe0), .busy(busy0), .done(done0), .bus(bus0));
  nic_mon #(.WE_CLKS(WE)) m1 (.clk(clk), .rst_n(rst_n), .clr(clr), .we_n(we1),
    .cle(cle1), .ale(ale1), .oe(oe1), .busy(busy1), .done(done1), .bus(bus1));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int gn(input int d);
    return (d == 0) ? m0.n : m1.n;
  endfunction
  function automatic logic [9:0] gbk(input int d, input int i);
    return (d == 0) ? {m0.kind_q[i], m0.byte_q[i]} : {m1.kind_q[i], m1.byte_q[i]};
  endfunction

  // command bytes get kind 2'b10, address bytes 2'b01; byte i sits at [8i+:8]
  task automatic expect_seq(input int d, input string tag, input int nc, input logic [23:0] c,
                            input int na, input logic [31:0] a);
    chk(gn(d) == nc + na, {tag, " byte count"}, gn(d), nc + na);
    for (int i = 0; i < nc && i < gn(d); i++)
      chk(gbk(d, i) == {2'b10, c[8*i +: 8]}, {tag, " cmd byte"}, gbk(d, i), {2'b10, c[8*i +: 8]});
    for (int i = 0; i < na && nc + i < gn(d); i++)
      chk(gbk(d, nc + i) == {2'b01, a[8*i +: 8]}, {tag, " addr byte"}, gbk(d, nc + i),
          {2'b01, a[8*i +: 8]});
    chk(((d == 0) ? m0.bad_we : m1.bad_we) == 0, "R9 strobe width",
        (d == 0) ? m0.bad_we : m1.bad_we, 0);
    chk(((d == 0) ? m0.settle : m1.settle) == SETTLE, "R10 settle clocks",
        (d == 0) ? m0.settle : m1.settle, SETTLE);
    chk(((d == 0) ? m0.dones : m1.dones) == 1, "R10 done pulses",
        (d == 0) ? m0.dones : m1.dones, 1);
  endtask

  task automatic run_req(input logic [7:0] cmd, input logic hc, input logic [9:0] col,
                         input logic hp, input logic [23:0] page);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    req_cmd = cmd; req_hc = hc; req_col = col; req_hp = hp; req_page = page; req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    while (busy0 || busy1) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk(!busy0 && !done0 && !cle0 && !ale0 && we0 && !oe0, "R1 reset u0",
        {busy0, done0, cle0, ale0, we0, oe0}, 6'b000010);
    chk(!busy1 && !done1 && !cle1 && !ale1 && we1 && !oe1, "R1 reset u1",
        {busy1, done1, cle1, ale1, we1, oe1}, 6'b000010);
  endtask

  task automatic t_plain_full;
    run_req(8'h00, 1'b1, 10'd5, 1'b1, 24'h123456);
    expect_seq(0, "R2 R7 R8 plain u0", 1, 24'h00, 4, 32'h1234_5605);
    expect_seq(1, "R2 R7 R8 plain u1", 1, 24'h00, 3, 32'h0034_5605);
  endtask

  task automatic t_seq_low;
    run_req(8'h80, 1'b1, 10'h010, 1'b1, 24'h000102);
    expect_seq(0, "R6 seq low u0", 2, 24'h00_8000, 4, 32'h0001_0210);
    expect_seq(1, "R6 seq low u1", 2, 24'h00_8000, 3, 32'h0001_0210);
  endtask

  task automatic t_seq_255;
    run_req(8'h80, 1'b1, 10'd255, 1'b1, 24'h000000);
    expect_seq(0, "R6 seq col255 u0", 2, 24'h00_8000, 4, 32'h0000_00FF);
    expect_seq(1, "R6 seq col255 u1", 2, 24'h00_8000, 3, 32'h0000_00FF);
  endtask

  task automatic t_seq_mid;
    run_req(8'h80, 1'b1, 10'h12C, 1'b1, 24'h000203);
    expect_seq(0, "R4 seq col300 u0", 2, 24'h00_8001, 4, 32'h0002_032C);
    expect_seq(1, "R3 seq col300 u1", 3, 24'h80_50FF, 3, 32'h0002_032C);
  endtask

  task automatic t_seq_511;
    run_req(8'h80, 1'b1, 10'd511, 1'b1, 24'h000000);
    expect_seq(0, "R4 seq col511 u0", 2, 24'h00_8001, 4, 32'h0000_00FF);
    expect_seq(1, "R3 seq col511 u1", 3, 24'h80_50FF, 3, 32'h0000_00FF);
  endtask

  task automatic t_seq_oob;
    run_req(8'h80, 1'b1, 10'h208, 1'b1, 24'h000304);
    expect_seq(0, "R5 seq col520 u0", 2, 24'h00_8050, 4, 32'h0003_0408);
    expect_seq(1, "R3 seq col520 u1", 3, 24'h80_50FF, 3, 32'h0003_0408);
  endtask

  task automatic t_seq_nocol;
    run_req(8'h80, 1'b0, 10'h3FF, 1'b1, 24'h00AB12);
    expect_seq(0, "R6 R7 seq no col u0", 2, 24'h00_8000, 3, 32'h0000_AB12);
    expect_seq(1, "R6 R7 seq no col u1", 2, 24'h00_8000, 2, 32'h0000_AB12);
  endtask

  task automatic t_no_addr;
    run_req(8'h70, 1'b0, 10'h155, 1'b0, 24'hFFFFFF);
    expect_seq(0, "R2 R7 R8 no addr u0", 1, 24'h70, 0, 32'h0);
    expect_seq(1, "R2 R7 R8 no addr u1", 1, 24'h70, 0, 32'h0);
  endtask

  task automatic t_col_only;
    run_req(8'h90, 1'b1, 10'h000, 1'b0, 24'h123456);
    expect_seq(0, "R7 col only u0", 1, 24'h90, 1, 32'h00);
    expect_seq(1, "R7 col only u1", 1, 24'h90, 1, 32'h00);
  endtask

  task automatic t_busy_ignore;
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    req_cmd = 8'h60; req_hc = 1'b0; req_hp = 1'b1; req_page = 24'h000001; req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    repeat (5) @(negedge clk);
    req_cmd = 8'h70; req_hc = 1'b1; req_col = 10'd7; req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    while (busy0 || busy1) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(!busy0 && !busy1, "R11 stays idle after drop", {busy0, busy1}, 0);
    expect_seq(0, "R11 ignored u0", 1, 24'h60, 3, 32'h0000_0001);
    expect_seq(1, "R11 ignored u1", 1, 24'h60, 2, 32'h0000_0001);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_plain_full();
    t_seq_low();
    t_seq_255();
    t_seq_mid();
    t_seq_511();
    t_seq_oob();
    t_seq_nocol();
    t_no_addr();
    t_col_only();
    t_busy_ignore();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule